// File: doc/BRIEF.md
# Programmable Asynchronous Serial Receiver

The block turns a single asynchronous serial line into parallel words. It runs entirely on the receive clock, which is either the bit clock itself or 16 or 64 times the bit rate. Each frame begins with a low start bit, carries 7 or 8 data bits with the least significant bit first, may carry a parity bit, and ends with one or two high stop bits. The word length, parity sense, stop-bit count and clock-division ratio come in on static configuration pins. These pins are only changed while the line is idle.

When a frame completes, the word is presented together with a parity-error flag and a framing-error flag, and a ready level is raised. The consumer pulses a read strobe to take the word. If a further word completes before that read, the overrun flag is raised. In the divided modes the receiver qualifies the start bit again at its midpoint, so that short low glitches are dropped. Later bits are then sampled at their centres.

Top module: `async_rx_core`

## Requirements
- R1: Once reset has been applied, rx_word is 0 and rx_ready, err_frame, err_parity and err_overrun are all 0.
- R2: div_sel 00 selects divide-by-1, 01 selects divide-by-16, and 10 or 11 selects divide-by-64. In a divided mode, a high-to-low line transition seen at clock edge E0 starts a frame. The line is sampled again at edge E0+N/2. If it is high there, the event is dropped and the receiver waits for the next high-to-low transition.
- R3: In a divided mode, every later bit (data, parity, stop) is sampled N clock edges after the previous sample. The first of these samples is taken N edges after the start-bit midpoint.
- R4: In divide-by-1 mode, a low line sampled at an edge while the receiver is idle is the start bit. Each following edge samples the next bit, and the start bit is not sampled again.
- R5: Data bits arrive least significant first. wlen_sel=1 selects 8 data bits. wlen_sel=0 selects 7 data bits, and rx_word[7] is then 0.
- R6: par_sel 00 or 11 means no parity bit, and err_parity is then 0. par_sel 01 is even parity and 10 is odd parity. err_parity is 1 when the number of ones over the data bits plus the parity bit does not have the selected sense.
- R7: err_frame is 1 exactly when the first stop-bit sample is low.
- R8: rx_word, err_frame and err_parity change only at the edge that samples the first stop bit, and rx_ready goes to 1 at that same edge. rx_ready stays at 1 until rd_ack is sampled high at an edge with no completion, which clears it.
- R9: A completion while rx_ready is still 1 and rd_ack is low sets err_overrun to 1. Any other completion sets err_overrun to 0. A read with no completion in the same cycle clears it.
- R10: With stop_sel=1, the line is ignored for one more bit time after the first stop sample. With stop_sel=0, a start bit can be taken immediately after the first stop sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock (bit clock or 16/64 times the bit rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Serial line, idle high, synchronous to clk |
| wlen_sel | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| par_sel | input | 2 | 00/11 none, 01 even, 10 odd |
| stop_sel | input | 1 | 1 = two stop bits, 0 = one |
| div_sel | input | 2 | 00 divide-by-1, 01 divide-by-16, 10/11 divide-by-64 |
| rd_ack | input | 1 | Read strobe that consumes the presented word |
| rx_word | output | 8 | Received data word |
| rx_ready | output | 1 | A word is waiting to be read |
| err_frame | output | 1 | First stop bit of the presented word was low |
| err_parity | output | 1 | Parity of the presented word did not match |
| err_overrun | output | 1 | The previous word was overwritten before it was read |

## Verification
The assertions take for granted that the line is already synchronous to the receive clock. They also assume that the four configuration inputs hold steady from the start of a frame until the receiver is idle again; one property states this condition directly. The stimulus satisfies both. It changes rxd and the configuration only just after falling clock edges, and it reconfigures only after an idle gap that follows the last stop bit. Glitches sent in the divided modes last exactly half a bit time, which places the midpoint re-sample on the first high clock.

// File: rtl/async_rx_pkg.sv
// Shared definitions for the asynchronous serial receiver.
// Assumes: the word register is never wider than eight bits.
package async_rx_pkg;
    localparam int unsigned WORD_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              pbit;
        logic              stop_lvl;
    } frame_t;
endpackage

// File: rtl/async_rx_timer.sv
// Bit-interval timer. In the divided modes it counts receive clocks and
// pulses tick at the half-bit point during the start phase and at the
// full-bit point after that. In divide-by-1 mode every clock is a tick.
// Assumes: the frame controller raises cnt_clr on the edge that detects a start.
module async_rx_timer #(
    parameter int unsigned MID_N  = 16,
    parameter int unsigned HIGH_N = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] div_sel,
    input  logic       cnt_clr,
    input  logic       half_phase,
    output logic       single,
    output logic       tick
);
    localparam int unsigned CNT_W = $clog2(HIGH_N + 1);
    localparam logic [CNT_W-1:0] MID_FULL  = CNT_W'(MID_N);
    localparam logic [CNT_W-1:0] MID_HALF  = CNT_W'(MID_N / 2);
    localparam logic [CNT_W-1:0] HIGH_FULL = CNT_W'(HIGH_N);
    localparam logic [CNT_W-1:0] HIGH_HALF = CNT_W'(HIGH_N / 2);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] target;

    // Pick the count that ends the current interval.
    always_comb begin
        single = (div_sel == 2'b00);
        case (div_sel)
            2'b00:   target = CNT_ONE;
            2'b01:   target = half_phase ? MID_HALF : MID_FULL;
            default: target = half_phase ? HIGH_HALF : HIGH_FULL;
        endcase
        tick = single | (cnt == target);
    end

    // Interval counter, restarted at a start detection or at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_ONE;
        end else if (cnt_clr || tick) begin
            cnt <= CNT_ONE;
        end else begin
            cnt <= cnt + CNT_ONE;
        end
    end
endmodule

// File: rtl/async_rx_frame.sv
// Frame sequencer. It detects the start bit, checks it again at mid-bit in
// the divided modes, and collects the data and parity bits. It raises done
// at the edge that samples the first stop bit, and in two-stop mode it then
// waits one more bit time before returning to idle.
// Assumes: configuration is stable while busy is high.
module async_rx_frame
    import async_rx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rxd,
    input  logic   tick,
    input  logic   single,
    input  logic   wlen_sel,
    input  logic   par_on,
    input  logic   stop_sel,
    output logic   cnt_clr,
    output logic   half_phase,
    output logic   done,
    output logic   busy,
    output frame_t frame
);
    rx_state_e         state;
    logic [2:0]        bit_idx;
    logic [2:0]        last_idx;
    logic              line_q;
    logic              start_go;
    logic [WORD_W-1:0] data_q;
    logic              pbit_q;

    // Start detection and the strobes for the timer and the result register.
    always_comb begin
        last_idx   = wlen_sel ? 3'd7 : 3'd6;
        start_go   = (state == ST_IDLE) && (single ? !rxd : (line_q && !rxd));
        cnt_clr    = start_go;
        half_phase = (state == ST_START);
        done       = (state == ST_STOP1) && tick;
        busy       = (state != ST_IDLE);
        frame.data     = data_q;
        frame.pbit     = pbit_q;
        frame.stop_lvl = rxd;
    end

    // Previous line level, used to find the falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b1;
        else        line_q <= rxd;
    end

    // Frame state machine and bit capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            data_q  <= '0;
            pbit_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_go) begin
                        state   <= single ? ST_DATA : ST_START;
                        bit_idx <= '0;
                        data_q  <= '0;
                    end
                end
                ST_START: begin
                    if (tick) state <= rxd ? ST_IDLE : ST_DATA;
                end
                ST_DATA: begin
                    if (tick) begin
                        data_q[bit_idx] <= rxd;
                        if (bit_idx == last_idx) state <= par_on ? ST_PAR : ST_STOP1;
                        else                     bit_idx <= bit_idx + 3'd1;
                    end
                end
                ST_PAR: begin
                    if (tick) begin
                        pbit_q <= rxd;
                        state  <= ST_STOP1;
                    end
                end
                ST_STOP1: begin
                    if (tick) state <= stop_sel ? ST_STOP2 : ST_IDLE;
                end
                ST_STOP2: begin
                    if (tick) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/async_rx_result.sv
// Result register. It computes parity over the received bits, latches the
// word and both error flags when a frame completes, and keeps the ready and
// overrun levels that the read strobe clears.
// Assumes: done lasts one clock per frame.
module async_rx_result
    import async_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  frame_t            frame,
    input  logic              wlen_sel,
    input  logic [1:0]        par_sel,
    input  logic              rd_ack,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_ready,
    output logic              err_frame,
    output logic              err_parity,
    output logic              err_overrun
);
    logic [WORD_W-1:0] masked;
    logic              ones_odd;
    logic              par_bad;

    // Drop the top data bit when the word length is seven.
    for (genvar i = 0; i < WORD_W; i++) begin : g_mask
        if (i == WORD_W - 1) begin : g_top
            assign masked[i] = frame.data[i] & wlen_sel;
        end else begin : g_low
            assign masked[i] = frame.data[i];
        end
    end

    // Compare the parity sense against the selected mode.
    always_comb begin
        ones_odd = (^masked) ^ frame.pbit;
        case (par_sel)
            2'b01:   par_bad = ones_odd;
            2'b10:   par_bad = !ones_odd;
            default: par_bad = 1'b0;
        endcase
    end

    // Latch the word at completion; a read clears ready and overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word     <= '0;
            rx_ready    <= 1'b0;
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
            err_overrun <= 1'b0;
        end else if (done) begin
            rx_word     <= masked;
            err_frame   <= !frame.stop_lvl;
            err_parity  <= par_bad;
            err_overrun <= rx_ready && !rd_ack;
            rx_ready    <= 1'b1;
        end else if (rd_ack) begin
            rx_ready    <= 1'b0;
            err_overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/async_rx_core.sv
// Top level of the asynchronous serial receiver: timer, frame sequencer
// and result register.
// Assumes: rxd is synchronous to clk, and configuration changes only while idle.
module async_rx_core
    import async_rx_pkg::*;
#(
    parameter int unsigned MID_N  = 16,
    parameter int unsigned HIGH_N = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              wlen_sel,
    input  logic [1:0]        par_sel,
    input  logic              stop_sel,
    input  logic [1:0]        div_sel,
    input  logic              rd_ack,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_ready,
    output logic              err_frame,
    output logic              err_parity,
    output logic              err_overrun
);
    logic   tick;
    logic   single;
    logic   cnt_clr;
    logic   half_phase;
    logic   frame_done;
    logic   rx_busy;
    logic   par_on;
    frame_t frame;

    // A parity bit is present only for the even and odd codes.
    always_comb par_on = (par_sel == 2'b01) || (par_sel == 2'b10);

    async_rx_timer #(.MID_N(MID_N), .HIGH_N(HIGH_N)) u_timer (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .cnt_clr(cnt_clr),
        .half_phase(half_phase), .single(single), .tick(tick)
    );

    async_rx_frame u_frame (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick(tick), .single(single),
        .wlen_sel(wlen_sel), .par_on(par_on), .stop_sel(stop_sel),
        .cnt_clr(cnt_clr), .half_phase(half_phase), .done(frame_done),
        .busy(rx_busy), .frame(frame)
    );

    async_rx_result u_result (
        .clk(clk), .rst_n(rst_n), .done(frame_done), .frame(frame),
        .wlen_sel(wlen_sel), .par_sel(par_sel), .rd_ack(rd_ack),
        .rx_word(rx_word), .rx_ready(rx_ready), .err_frame(err_frame),
        .err_parity(err_parity), .err_overrun(err_overrun)
    );
endmodule

// File: rtl/async_rx_chk.sv
// Property checker for the receiver, attached to the top by bind.
// Assumes: it sees the top's completion and busy signals.
module async_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_ack,
    input logic       wlen_sel,
    input logic [1:0] par_sel,
    input logic       stop_sel,
    input logic [1:0] div_sel,
    input logic [7:0] rx_word,
    input logic       rx_ready,
    input logic       err_frame,
    input logic       err_parity,
    input logic       err_overrun,
    input logic       frame_done,
    input logic       rx_busy
);
    // R1
    reset_state_chk: assert property (@(posedge clk) !rst_n |=>
        (rx_word == 8'h00 && !rx_ready && !err_frame && !err_parity && !err_overrun));

    // R8
    ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> rx_ready);

    // R8
    ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack && !frame_done |=> !rx_ready);

    // R8
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(rx_word) && $stable(err_frame) && $stable(err_parity));

    // R9
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && rx_ready && !rd_ack |=> err_overrun);

    // R9
    overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done && !rd_ack |=> $stable(err_overrun));

    // R5
    seven_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && !wlen_sel |=> !rx_word[7]);

    // R6
    no_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && (par_sel == 2'b00 || par_sel == 2'b11) |=> !err_parity);

    // R2 input assumption: configuration held while a frame is in progress
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_busy |=> $stable({wlen_sel, par_sel, stop_sel, div_sel}));
endmodule

bind async_rx_core async_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_ack(rd_ack), .wlen_sel(wlen_sel),
    .par_sel(par_sel), .stop_sel(stop_sel), .div_sel(div_sel),
    .rx_word(rx_word), .rx_ready(rx_ready), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun),
    .frame_done(frame_done), .rx_busy(rx_busy)
);

// File: tb/async_rx_core_tb.sv
// Bench for the receiver. A behavioural model holds a queue of expected
// completions, each with its edge index, and the outputs are compared with
// that model on every falling clock edge.
module async_rx_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    typedef struct {
        int         at;
        logic [7:0] w;
        logic       fe;
        logic       pe;
    } ev_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       wlen_sel = 1'b1;
    logic [1:0] par_sel = 2'b00;
    logic       stop_sel = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       rd_ack = 1'b0;
    logic [7:0] rx_word;
    logic       rx_ready, err_frame, err_parity, err_overrun;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R4";
    ev_t   evq[$];
    logic [7:0] exp_word = 8'h00;
    logic  exp_rdy = 1'b0, exp_fe = 1'b0, exp_pe = 1'b0, exp_ovr = 1'b0;

    async_rx_core u_dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .wlen_sel(wlen_sel),
        .par_sel(par_sel), .stop_sel(stop_sel), .div_sel(div_sel),
        .rd_ack(rd_ack), .rx_word(rx_word), .rx_ready(rx_ready),
        .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h at edge %0d", tag, what, act, exp, cyc);
        end
    endtask

    // Reference model, advanced at every rising edge.
    always @(posedge clk) begin
        cyc++;
        if (cyc >= WD_LIMIT) begin
            errors++;
            $display("FAIL R8 watchdog actual %0d expected below %0d", cyc, WD_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        if (!rst_n) begin
            exp_word = 8'h00; exp_rdy = 0; exp_fe = 0; exp_pe = 0; exp_ovr = 0;
        end else if (evq.size() > 0 && evq[0].at == cyc) begin
            exp_ovr  = exp_rdy && !rd_ack;
            exp_rdy  = 1'b1;
            exp_word = evq[0].w;
            exp_fe   = evq[0].fe;
            exp_pe   = evq[0].pe;
            void'(evq.pop_front());
        end else if (rd_ack) begin
            exp_rdy = 1'b0;
            exp_ovr = 1'b0;
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (cyc >= 1) begin
            check(cur_tag, "rx_word", int'(rx_word), int'(exp_word));
            check("R8", "rx_ready", int'(rx_ready), int'(exp_rdy));
            check("R7", "err_frame", int'(err_frame), int'(exp_fe));
            check("R6", "err_parity", int'(err_parity), int'(exp_pe));
            check("R9", "err_overrun", int'(err_overrun), int'(exp_ovr));
        end
    end

    task automatic drive(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    function automatic int div_n();
        return (div_sel == 2'b00) ? 1 : (div_sel == 2'b01) ? 16 : 64;
    endfunction

    // Send one frame and queue its expected completion; called at a falling edge.
    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                              input bit low_stop2, input int gap);
        int n, h, nd, p;
        logic [7:0] dm;
        logic pb;
        ev_t ev;
        n  = div_n();
        h  = (n == 1) ? 0 : n / 2;
        nd = wlen_sel ? 8 : 7;
        p  = (par_sel == 2'b01 || par_sel == 2'b10) ? 1 : 0;
        dm = wlen_sel ? d : {1'b0, d[6:0]};
        pb = (par_sel == 2'b10) ? ~(^dm) : (^dm);
        pb = pb ^ bad_par;
        ev.at = cyc + 1 + h + n * (nd + 1 + p);
        ev.w  = dm;
        ev.fe = bad_stop;
        ev.pe = (p == 1) && bad_par;
        evq.push_back(ev);
        drive(1'b0, n);
        for (int i = 0; i < nd; i++) drive(d[i], n);
        if (p == 1) drive(pb, n);
        drive(!bad_stop, n);
        if (stop_sel) drive(!low_stop2, n);
        for (int g = 0; g < gap; g++) drive(1'b1, n);
    endtask

    task automatic do_read();
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "reset word", int'(rx_word), 0);
        check("R1", "reset ready", int'(rx_ready), 0);
        check("R1", "reset flags", int'({err_frame, err_parity, err_overrun}), 0);

        // R4 divide-by-1, 8 bits, no parity, one stop
        cur_tag = "R4";
        send_frame(8'hA5, 0, 0, 0, 2);
        do_read();
        send_frame(8'h3C, 0, 0, 0, 2);
        do_read();

        // R10 with one stop bit a start may follow at once; R9 the second completion overruns
        cur_tag = "R10";
        send_frame(8'h81, 0, 0, 0, 0);
        send_frame(8'h7E, 0, 0, 0, 2);
        do_read();

        // R10 with two stop bits a low line in the second stop time is ignored
        stop_sel = 1'b1;
        send_frame(8'h5A, 0, 0, 1, 3);
        do_read();
        stop_sel = 1'b0;

        // R3 divide-by-16 with even parity, good then bad; R6
        cur_tag = "R3";
        div_sel = 2'b01; par_sel = 2'b01;
        drive(1'b1, 20);
        send_frame(8'hC3, 0, 0, 0, 2);
        do_read();
        cur_tag = "R6";
        send_frame(8'h17, 1, 0, 0, 2);
        do_read();

        // R5 seven bits, odd parity, top bit forced to zero
        cur_tag = "R5";
        wlen_sel = 1'b0; par_sel = 2'b10;
        drive(1'b1, 4);
        send_frame(8'hFF, 0, 0, 0, 2);
        do_read();
        send_frame(8'h2A, 1, 0, 0, 2);
        do_read();

        // R2 a half-bit glitch is dropped, then a real frame is received
        cur_tag = "R2";
        wlen_sel = 1'b1; par_sel = 2'b00;
        drive(1'b1, 4);
        drive(1'b0, 8);
        drive(1'b1, 40);
        send_frame(8'h96, 0, 0, 0, 2);
        do_read();

        // R7 divide-by-64, two stop bits, first stop low
        cur_tag = "R7";
        div_sel = 2'b10; stop_sel = 1'b1;
        drive(1'b1, 2);
        send_frame(8'h4D, 0, 1, 0, 2);
        do_read();
        send_frame(8'hB2, 0, 0, 0, 2);

        // R9 unread word then a further one; code 11 also divides by 64 (R2)
        cur_tag = "R9";
        div_sel = 2'b11; stop_sel = 1'b0; par_sel = 2'b11;
        drive(1'b1, 2);
        send_frame(8'hE1, 0, 0, 0, 2);
        check("R9", "overrun after unread word", int'(err_overrun), 1);
        do_read();
        check("R8", "ready cleared by read", int'(rx_ready), 0);

        drive(1'b1, 4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule